// File: doc/BRIEF.md
# Lane-to-Sample Transport Demapper

This block sits behind a multi-lane serial link receiver that has already aligned and descrambled its lanes. Each clock cycle it takes one 32-bit word from each of eight lanes and rebuilds the 12-bit samples of a single converter channel from them. A frame on each lane is eight octets long, so it arrives in two consecutive beats. The block keeps the first beat of every lane and joins it to the second. It then strips the four zero tail bits and cuts the rest into five samples per lane. The samples from all lanes are interleaved into one 480-bit word, which holds 40 samples in time order.

Frame alignment comes from a start marker given by the link layer. Beats that arrive while the input valid is low are skipped. A finished output word is shown for one cycle with a valid pulse. A pulse on a separate flag reports any lane whose tail bits were not zero.

Top module: `lane_sample_demapper`

## Requirements
- R1: In each lane word, bits [7:0] hold the earliest octet. Before packing, the octet order of each word is reversed, so the earliest octet ends up in bits [31:24].
- R2: For each lane, the byte-reversed word of the first beat of a frame becomes bits [63:32] of that lane's 64-bit frame. The word of the following accepted beat becomes bits [31:0].
- R3: Bits [3:0] of each lane frame are dropped. Bits [63:4] hold five 12-bit samples, and position p (0 to 4) sits at bits [63-12p:52-12p], with the earliest sample at the most significant end.
- R4: Position p of lane L (lane L arrives on lane_data[32L+31:32L]) is output sample k = 8p + L. It is placed at out_samples[12k+11:12k] with its bits unchanged, as signed two's complement.
- R5: The cycle after the second beat of a frame is accepted, out_valid is high for exactly one cycle. It is never high on two cycles in a row, and it stays low after a first beat.
- R6: An accepted beat with frame_start high is always the first beat of a new frame. Any half-received frame is thrown away.
- R7: While in_valid is low, lane_data and frame_start have no effect, and the frame phase holds.
- R8: tail_err is high for one cycle, together with out_valid, when the tail bits of any lane in that frame are not zero. Otherwise it is low.
- R9: After reset, out_valid and tail_err are low and out_samples is zero. out_samples keeps its last value while out_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Lane words on lane_data are valid this cycle |
| frame_start | input | 1 | Marks the current valid beat as the first half of a frame |
| lane_data | input | 256 | Eight 32-bit lane words, lane L at bits [32L+31:32L] |
| out_valid | output | 1 | One-cycle strobe for a complete 40-sample word |
| out_samples | output | 480 | 40 samples of 12 bits, sample k at bits [12k+11:12k] |
| tail_err | output | 1 | Nonzero tail bits seen in the frame just delivered |

## Verification
A table of frames built from distinct sample seeds is sent with and without the start marker. Because each sample value differs from the others, any error in octet order, half order, sample position or lane interleave shows up as a wrong sample. Some frames carry a nonzero tail on one lane, which separates a correct tail check from one that never fires or checks the wrong bits. Directed sequences cover three more cases: a stall between the two halves while the marker and data toggle, a restart in the middle of a frame, and holding of the output. These show that the phase advances only on valid beats and that the marker restarts the frame.

// File: rtl/lsd_pkg.sv
package lsd_pkg;
  localparam int unsigned LSD_LANES    = 8;
  localparam int unsigned LSD_LANE_W   = 32;
  localparam int unsigned LSD_SAMP_W   = 12;
  localparam int unsigned LSD_TAIL_W   = 4;
  localparam int unsigned LSD_FRAME_W  = 2 * LSD_LANE_W;
  localparam int unsigned LSD_SPL      = (LSD_FRAME_W - LSD_TAIL_W) / LSD_SAMP_W;
  localparam int unsigned LSD_OUT_W    = LSD_LANES * LSD_SPL * LSD_SAMP_W;
endpackage

// File: rtl/lsd_phase_track.sv
module lsd_phase_track (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic frame_start,
  output logic first_beat,
  output logic second_beat
);
  logic half_q, half_d;

  always_comb begin
    first_beat  = in_valid && (frame_start || !half_q);
    second_beat = in_valid && !frame_start && half_q;
    half_d      = half_q;
    if (in_valid) half_d = first_beat;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) half_q <= 1'b0;
    else        half_q <= half_d;
  end

  // R6: marker forces the first-half state
  a_r6_start_sets_half: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && frame_start) |=> half_q);
  // R7: phase frozen without valid input
  a_r7_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(half_q));
  // R2: second half closes the frame
  a_r2_second_closes: assert property (@(posedge clk) disable iff (!rst_n)
    second_beat |=> !half_q);
endmodule

// File: rtl/lsd_lane_unpack.sv
module lsd_lane_unpack #(
  parameter int unsigned LANE_W = 32,
  parameter int unsigned SAMP_W = 12,
  parameter int unsigned TAIL_W = 4,
  localparam int unsigned FRAME_W = 2 * LANE_W,
  localparam int unsigned SPL     = (FRAME_W - TAIL_W) / SAMP_W,
  localparam int unsigned OCTETS  = LANE_W / 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  capture_hi,
  input  logic [LANE_W-1:0]     word_in,
  output logic [SPL*SAMP_W-1:0] samples,
  output logic                  tail_bad
);
  logic [LANE_W-1:0]  swapped;
  logic [LANE_W-1:0]  hi_q, hi_d;
  logic [FRAME_W-1:0] frame;

  always_comb begin
    for (int o = 0; o < OCTETS; o++)
      swapped[8*(OCTETS-1-o) +: 8] = word_in[8*o +: 8];
  end

  always_comb begin
    hi_d = hi_q;
    if (capture_hi) hi_d = swapped;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hi_q <= '0;
    else        hi_q <= hi_d;
  end

  always_comb begin
    frame    = {hi_q, swapped};
    tail_bad = |frame[TAIL_W-1:0];
    for (int p = 0; p < SPL; p++)
      samples[SAMP_W*p +: SAMP_W] = frame[FRAME_W-1-SAMP_W*p -: SAMP_W];
  end
endmodule

// File: rtl/lane_sample_demapper.sv
module lane_sample_demapper
  import lsd_pkg::*;
#(
  parameter int unsigned LANES  = LSD_LANES,
  parameter int unsigned LANE_W = LSD_LANE_W,
  parameter int unsigned SAMP_W = LSD_SAMP_W,
  parameter int unsigned TAIL_W = LSD_TAIL_W,
  localparam int unsigned SPL   = (2 * LANE_W - TAIL_W) / SAMP_W,
  localparam int unsigned OUT_W = LANES * SPL * SAMP_W,
  localparam int unsigned IN_W  = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             frame_start,
  input  logic [IN_W-1:0]  lane_data,
  output logic             out_valid,
  output logic [OUT_W-1:0] out_samples,
  output logic             tail_err
);
  logic first_beat, second_beat;
  logic [SPL*SAMP_W-1:0] lane_samp [LANES];
  logic [LANES-1:0]      lane_tail_bad;
  logic [OUT_W-1:0]      woven;
  logic [OUT_W-1:0]      samp_q, samp_d;
  logic                  vld_q, vld_d, err_q, err_d;

  lsd_phase_track u_phase (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .frame_start (frame_start),
    .first_beat  (first_beat),
    .second_beat (second_beat)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    lsd_lane_unpack #(
      .LANE_W (LANE_W),
      .SAMP_W (SAMP_W),
      .TAIL_W (TAIL_W)
    ) u_unpack (
      .clk        (clk),
      .rst_n      (rst_n),
      .capture_hi (first_beat),
      .word_in    (lane_data[LANE_W*l +: LANE_W]),
      .samples    (lane_samp[l]),
      .tail_bad   (lane_tail_bad[l])
    );
  end

  always_comb begin
    for (int l = 0; l < LANES; l++)
      for (int p = 0; p < SPL; p++)
        woven[SAMP_W*(LANES*p + l) +: SAMP_W] = lane_samp[l][SAMP_W*p +: SAMP_W];
  end

  always_comb begin
    samp_d = samp_q;
    vld_d  = second_beat;
    err_d  = second_beat && (|lane_tail_bad);
    if (second_beat) samp_d = woven;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      samp_q <= '0;
      vld_q  <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      samp_q <= samp_d;
      vld_q  <= vld_d;
      err_q  <= err_d;
    end
  end

  assign out_samples = samp_q;
  assign out_valid   = vld_q;
  assign tail_err    = err_q;

  // R5: strobe never lasts two cycles
  a_r5_valid_alternates: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);
  // R5: first half alone yields no output
  a_r5_first_no_output: assert property (@(posedge clk) disable iff (!rst_n)
    first_beat |=> !out_valid);
  // R8: error only alongside a delivered word
  a_r8_err_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
    tail_err |-> out_valid);
  // R9: output word held between strobes
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_samples));
endmodule

// File: tb/lane_sample_demapper_test.sv
module lane_sample_demapper_test;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid;
  logic         frame_start;
  logic [255:0] lane_data;
  logic         out_valid;
  logic [479:0] out_samples;
  logic         tail_err;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  lane_sample_demapper uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .frame_start(frame_start),
    .lane_data(lane_data), .out_valid(out_valid), .out_samples(out_samples),
    .tail_err(tail_err)
  );

  localparam int         NV = 6;
  localparam int         VSEED [NV] = '{1, 2, 77, 300, 1023, 4095};
  localparam logic [3:0] VTAIL [NV] = '{4'h0, 4'h0, 4'h1, 4'h0, 4'h8, 4'h0};
  localparam bit         VFS   [NV] = '{1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1};

  function automatic logic [11:0] samp(int seed, int k);
    int v;
    v = seed * 37 + k * 131 + k * k * seed;
    return 12'(v ^ (seed >>> 2));
  endfunction

  function automatic logic [31:0] bswap(logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  // returns {first-beat lane data, second-beat lane data}
  function automatic logic [511:0] build(int seed, logic [3:0] tail, int badl);
    logic [255:0] a, b;
    logic [63:0]  f;
    for (int l = 0; l < 8; l++) begin
      for (int p = 0; p < 5; p++) f[63-12*p -: 12] = samp(seed, 8*p + l);
      f[3:0] = (l == badl) ? tail : 4'h0;
      a[32*l +: 32] = bswap(f[63:32]);
      b[32*l +: 32] = bswap(f[31:0]);
    end
    return {a, b};
  endfunction

  function automatic logic [479:0] expect_word(int seed);
    logic [479:0] e;
    for (int k = 0; k < 40; k++) e[12*k +: 12] = samp(seed, k);
    return e;
  endfunction

  task automatic check(string req, logic [479:0] act, logic [479:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic beat(logic [255:0] d, logic fs);
    in_valid = 1'b1; frame_start = fs; lane_data = d;
    @(negedge clk);
    in_valid = 1'b0; frame_start = 1'b0;
  endtask

  task automatic idle(logic [255:0] junk);
    in_valid = 1'b0; frame_start = 1'b1; lane_data = junk;
    @(negedge clk);
    frame_start = 1'b0;
  endtask

  task automatic report;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      report();
    end
  end

  initial begin
    logic [511:0] fr, fr2;
    logic [479:0] held;
    rst_n = 1'b0; in_valid = 1'b0; frame_start = 1'b0; lane_data = '0;
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 reset valid", 480'(out_valid), 480'(0));
    check("R9 reset err",   480'(tail_err),  480'(0));
    check("R9 reset data",  out_samples,     480'(0));
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R2 R3 R4 R5 R8: table of frames
    for (int i = 0; i < NV; i++) begin
      fr = build(VSEED[i], VTAIL[i], VSEED[i] % 8);
      beat(fr[511:256], VFS[i]);
      check("R5 no valid after first half", 480'(out_valid), 480'(0));
      beat(fr[255:0], 1'b0);
      check("R5 valid after second half", 480'(out_valid), 480'(1));
      check("R1 R2 R3 R4 sample word", out_samples, expect_word(VSEED[i]));
      check("R8 tail flag", 480'(tail_err), 480'(VTAIL[i] != 0));
    end

    // R9 hold and R5 single-cycle strobe
    held = out_samples;
    lane_data = ~lane_data;
    @(negedge clk);
    check("R5 strobe one cycle", 480'(out_valid), 480'(0));
    check("R8 flag one cycle", 480'(tail_err), 480'(0));
    check("R9 output held", out_samples, held);

    // R7 stall between halves with marker and data toggling
    fr = build(555, 4'h0, 0);
    beat(fr[511:256], 1'b1);
    idle({8{32'hDEADBEEF}});
    idle({8{32'h12345678}});
    check("R7 no valid during stall", 480'(out_valid), 480'(0));
    beat(fr[255:0], 1'b0);
    check("R7 valid after stall", 480'(out_valid), 480'(1));
    check("R7 word after stall", out_samples, expect_word(555));

    // R6 restart mid-frame
    fr  = build(901, 4'h0, 0);
    fr2 = build(2222, 4'h0, 0);
    beat(fr2[511:256], 1'b1);
    beat(fr[511:256], 1'b1);
    check("R6 restart gives no output", 480'(out_valid), 480'(0));
    beat(fr[255:0], 1'b0);
    check("R6 word after restart", out_samples, expect_word(901));

    // R4 signed values pass unchanged: all samples at extremes
    begin
      logic [255:0] a, b;
      logic [63:0]  f;
      logic [479:0] e;
      for (int l = 0; l < 8; l++) begin
        for (int p = 0; p < 5; p++)
          f[63-12*p -: 12] = ((8*p + l) % 2 == 0) ? 12'h800 : 12'h7FF;
        f[3:0] = 4'h0;
        a[32*l +: 32] = bswap(f[63:32]);
        b[32*l +: 32] = bswap(f[31:0]);
      end
      for (int k = 0; k < 40; k++) e[12*k +: 12] = (k % 2 == 0) ? 12'h800 : 12'h7FF;
      beat(a, 1'b0);
      beat(b, 1'b0);
      check("R4 signed extremes", out_samples, e);
      check("R8 clean tail", 480'(tail_err), 480'(0));
    end

    finished = 1;
    report();
  end
endmodule